// File: doc/BRIEF.md
# Receive FIFO with Trigger Level and Idle Timeout

This block buffers bytes that arrive from a serial receiver. Each byte is offered on a one-cycle valid strobe. The byte is stored only while receive is enabled and while there is room. The host drains the buffer one byte per read strobe. It can watch the live occupancy on a separate count output.

A programmable trigger level decides when the host is told to come and read. Once the fill level reaches the trigger, a data-ready flag rises. If the interrupt enable is set, a receive interrupt is raised with it. Bytes that arrive while the level is still below the trigger each restart an idle timer of fifteen character times. If no further byte arrives before that timer runs out, the flag and the interrupt are forced on, so that a short tail of data is not stranded.

The host sets the trigger level and empties the buffer through a single control-write port. The length of one character time is a parameter given in clock cycles.

Top module: `rxf_top`

## Requirements
- R1: After reset the count is 0, data-ready and the interrupt are low, and the trigger level is 1.
- R2: Stored bytes come out in arrival order, across pointer wrap-around. `fill_count` shows the number held, which is 0 to 16.
- R3: A control write loads the trigger level from `cfg_data[7:6]`: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14.
- R4: A control write with `cfg_data[1]` set empties the buffer. It drops data-ready and the interrupt, and stops the idle timer. A flush takes priority over a push or a pop in the same cycle.
- R5: A valid byte is stored only while `rx_en` is high. Otherwise it has no effect.
- R6: A byte that arrives while 16 bytes are held is discarded, even if a pop happens in the same cycle.
- R7: When a push leaves the count at or above the trigger, data-ready is set. The interrupt is raised only if `rxi_en` is high.
- R8: A push that leaves the count below the trigger restarts a timer of 15 × CHAR_CYCLES cycles. On expiry, data-ready is set, and the interrupt is set if `rxi_en` is high. Data-ready becomes visible exactly 15 × CHAR_CYCLES cycles after the edge of the last such push.
- R9: A pop that leaves the count below the trigger clears data-ready. The interrupt falls together with data-ready.
- R10: A read strobe while the buffer is empty changes no state, and `rd_data` reads 0 whenever the buffer is empty.
- R11: A push and a pop in the same cycle leave the count unchanged. The trigger comparison uses the resulting count.
- R12: The interrupt is low in the cycle after any cycle in which `rxi_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; bytes are stored only while high |
| rxi_en | input | 1 | Receive interrupt enable |
| rx_valid | input | 1 | One-cycle strobe, a received byte is on rx_data |
| rx_data | input | DW | Received byte |
| cfg_wr | input | 1 | Control write strobe |
| cfg_data | input | 8 | Control value: [7:6] trigger select, [1] flush |
| rd_pop | input | 1 | Host read strobe; pops the head byte when not empty |
| rd_data | output | DW | Head byte, or 0 when empty |
| fill_count | output | $clog2(DEPTH+1) | Bytes currently held |
| rx_full | output | 1 | Data-ready: trigger reached or idle timeout |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The trigger path is driven with byte streams that climb to each trigger setting. These runs show that a level just below the trigger does not fire and the level at the trigger does. Pops just across the trigger show that data-ready is cleared only by falling below it. Single bytes left below the trigger are timed out and counted cycle by cycle. A second byte that arrives mid-wait shows that the timer restarts rather than accumulates, and a flush mid-wait shows that it is stopped. Filling past sixteen, and an overlapping push and pop, separate the discard rule from the simultaneous-access rule. Runs with enables low and reads from an empty buffer show that those inputs change nothing visible.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam int unsigned IDLE_CHARS = 15;

   typedef enum logic [1:0] {
      TRG_1  = 2'b00,
      TRG_4  = 2'b01,
      TRG_8  = 2'b10,
      TRG_14 = 2'b11
   } trig_sel_e;

   function automatic int unsigned trig_level(input trig_sel_e sel);
      case (sel)
         TRG_1:   return 1;
         TRG_4:   return 4;
         TRG_8:   return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          flush,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] head
);

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [PW-1:0] wr_inc, rd_inc;

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign wr_inc = wr_ptr + 1'b1;
         assign rd_inc = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_inc = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_inc = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (push) wr_ptr <= wr_inc;
         if (pop)  rd_ptr <= rd_inc;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr] <= wdata;
   end

   assign head = mem[rd_ptr];

endmodule

// File: rtl/rxf_level.sv
module rxf_level
   import rxf_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          cfg_wr,
   input  logic [1:0]    cfg_sel,
   input  logic          push,
   input  logic          pop,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          at_cap,
   output logic          below_next
);

   logic [CW-1:0] trig_q;
   logic [CW-1:0] cnt_next;

   always_comb begin
      cnt_next = count;
      if (flush)
         cnt_next = '0;
      else if (push && !pop)
         cnt_next = count + 1'b1;
      else if (pop && !push)
         cnt_next = count - 1'b1;
   end

   assign below_next = cnt_next < trig_q;
   assign empty      = (count == '0);
   assign at_cap     = (count == CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         trig_q <= CW'(1);
      end else begin
         count <= cnt_next;
         if (cfg_wr) trig_q <= CW'(trig_level(trig_sel_e'(cfg_sel)));
      end
   end

endmodule

// File: rtl/rxf_timer.sv
module rxf_timer #(
   parameter int unsigned TICKS = 240,
   localparam int unsigned TW   = (TICKS > 1) ? $clog2(TICKS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic stop,
   output logic expire
);

   logic          armed;
   logic [TW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         left  <= '0;
      end else if (stop) begin
         armed <= 1'b0;
      end else if (restart) begin
         armed <= 1'b1;
         left  <= TW'(TICKS - 1);
      end else if (armed) begin
         if (left == '0) armed <= 1'b0;
         else            left  <= left - 1'b1;
      end
   end

   assign expire = armed && (left == '0) && !restart && !stop;

endmodule

// File: rtl/rxf_top.sv
module rxf_top
   import rxf_pkg::*;
#(
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned DW          = 8,
   parameter int unsigned CHAR_CYCLES = 16,
   localparam int unsigned CW         = $clog2(DEPTH + 1),
   localparam int unsigned TICKS      = IDLE_CHARS * CHAR_CYCLES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_en,
   input  logic          rxi_en,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          cfg_wr,
   input  logic [7:0]    cfg_data,
   input  logic          rd_pop,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] fill_count,
   output logic          rx_full,
   output logic          rx_irq
);

   generate
      if (DEPTH < 14) begin : g_bad_depth
         $error("rxf_top: DEPTH must hold the largest trigger level (14)");
      end
      if (CHAR_CYCLES < 1) begin : g_bad_char
         $error("rxf_top: CHAR_CYCLES must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("rxf_top: DW must be at least 1");
      end
   endgenerate

   logic          flush;
   logic          empty, at_cap, below_next;
   logic          push_ok, pop_ok;
   logic          reach, restart, cancel, expire, set_evt;
   logic          full_d, irq_d;
   logic [DW-1:0] head;

   assign flush   = cfg_wr && cfg_data[1];
   assign pop_ok  = rd_pop && !empty && !flush;
   assign push_ok = rx_valid && rx_en && !at_cap && !flush;

   rxf_level #(.DEPTH(DEPTH)) u_level (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .cfg_wr     (cfg_wr),
      .cfg_sel    (cfg_data[7:6]),
      .push       (push_ok),
      .pop        (pop_ok),
      .count      (fill_count),
      .empty      (empty),
      .at_cap     (at_cap),
      .below_next (below_next)
   );

   rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_ok),
      .pop   (pop_ok),
      .flush (flush),
      .wdata (rx_data),
      .head  (head)
   );

   assign reach   = push_ok && !below_next;
   assign restart = push_ok && below_next;
   assign cancel  = reach && rxi_en;

   rxf_timer #(.TICKS(TICKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .stop    (flush || cancel),
      .expire  (expire)
   );

   assign set_evt = reach || expire;

   always_comb begin
      full_d = rx_full;
      if (flush)                    full_d = 1'b0;
      else if (set_evt)             full_d = 1'b1;
      else if (pop_ok && below_next) full_d = 1'b0;
   end

   always_comb begin
      irq_d = rx_irq;
      if (flush || !rxi_en) irq_d = 1'b0;
      else if (set_evt)     irq_d = 1'b1;
      else if (!full_d)     irq_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_full <= 1'b0;
         rx_irq  <= 1'b0;
      end else begin
         rx_full <= full_d;
         rx_irq  <= irq_d;
      end
   end

   assign rd_data = empty ? '0 : head;

endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_en,
   input logic          rxi_en,
   input logic          rx_valid,
   input logic          cfg_wr,
   input logic [7:0]    cfg_data,
   input logic          rd_pop,
   input logic [DW-1:0] rd_data,
   input logic [CW-1:0] fill_count,
   input logic          rx_full,
   input logic          rx_irq
);

   // R6
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= CW'(DEPTH));

   // R4
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr && cfg_data[1] |=> fill_count == '0 && !rx_full && !rx_irq);

   // R5
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> fill_count <= $past(fill_count));

   // R7
   irq_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rx_full);

   // R10
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count == '0 |-> rd_data == '0);

   // R11
   push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_en && rd_pop && fill_count != '0 &&
      fill_count != CW'(DEPTH) && !(cfg_wr && cfg_data[1]) |=> $stable(fill_count));

   // R12
   irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rxi_en |=> !rx_irq);

endmodule

bind rxf_top rxf_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_en      (rx_en),
   .rxi_en     (rxi_en),
   .rx_valid   (rx_valid),
   .cfg_wr     (cfg_wr),
   .cfg_data   (cfg_data),
   .rd_pop     (rd_pop),
   .rd_data    (rd_data),
   .fill_count (fill_count),
   .rx_full    (rx_full),
   .rx_irq     (rx_irq)
);

// File: tb/tb_rxf_top.sv
module tb_rxf_top;

   localparam int unsigned DEPTH = 16;
   localparam int unsigned DW    = 8;
   localparam int unsigned CHARC = 4;
   localparam int unsigned TOUT  = 15 * CHARC;
   localparam int unsigned CW    = $clog2(DEPTH + 1);

   localparam logic [1:0] OP_CFG  = 2'd0;
   localparam logic [1:0] OP_PUSH = 2'd1;
   localparam logic [1:0] OP_POP  = 2'd2;

   // op, arg, expected count, full, irq, expected read data (pop only)
   typedef struct packed {
      logic [1:0] op;
      logic [7:0] arg;
      logic [4:0] cnt;
      logic       full;
      logic       irq;
      logic [7:0] rd;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{OP_CFG,  8'h40, 5'd0, 1'b0, 1'b0, 8'h00},  // R3 trigger 4
      '{OP_PUSH, 8'h11, 5'd1, 1'b0, 1'b0, 8'h00},
      '{OP_PUSH, 8'h22, 5'd2, 1'b0, 1'b0, 8'h00},
      '{OP_PUSH, 8'h33, 5'd3, 1'b0, 1'b0, 8'h00},
      '{OP_PUSH, 8'h44, 5'd4, 1'b1, 1'b1, 8'h00},  // R7 reach 4
      '{OP_POP,  8'h00, 5'd3, 1'b0, 1'b0, 8'h11},  // R9
      '{OP_PUSH, 8'h55, 5'd4, 1'b1, 1'b1, 8'h00},
      '{OP_CFG,  8'h80, 5'd4, 1'b1, 1'b1, 8'h00},  // R3 trigger 8
      '{OP_POP,  8'h00, 5'd3, 1'b0, 1'b0, 8'h22},  // R9 3 < 8
      '{OP_CFG,  8'hC2, 5'd0, 1'b0, 1'b0, 8'h00},  // R4 flush
      '{OP_POP,  8'h00, 5'd0, 1'b0, 1'b0, 8'h00},  // R10 empty read
      '{OP_CFG,  8'h00, 5'd0, 1'b0, 1'b0, 8'h00},  // R3 trigger 1
      '{OP_PUSH, 8'hA5, 5'd1, 1'b1, 1'b1, 8'h00},
      '{OP_POP,  8'h00, 5'd0, 1'b0, 1'b0, 8'hA5}   // R2
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_en = 1'b1, rxi_en = 1'b1, rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          cfg_wr = 1'b0;
   logic [7:0]    cfg_data = '0;
   logic          rd_pop = 1'b0;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] fill_count;
   logic          rx_full, rx_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rxf_top #(.DEPTH(DEPTH), .DW(DW), .CHAR_CYCLES(CHARC)) dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxi_en(rxi_en),
      .rx_valid(rx_valid), .rx_data(rx_data), .cfg_wr(cfg_wr),
      .cfg_data(cfg_data), .rd_pop(rd_pop), .rd_data(rd_data),
      .fill_count(fill_count), .rx_full(rx_full), .rx_irq(rx_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req, input int c, input int f, input int i);
      check({req, " count"}, int'(fill_count), c);
      check({req, " full"},  int'(rx_full), f);
      check({req, " irq"},   int'(rx_irq), i);
   endtask

   task automatic do_push(input logic [7:0] d);
      @(negedge clk); rx_valid = 1'b1; rx_data = d;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic do_cfg(input logic [7:0] v);
      @(negedge clk); cfg_wr = 1'b1; cfg_data = v;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic do_pop(output logic [7:0] got);
      @(negedge clk); rd_pop = 1'b1; got = rd_data;
      @(negedge clk); rd_pop = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5ns * 100000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      logic [7:0] got;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_state("R1 reset", 0, 0, 0);
      check("R1 rd_data", int'(rd_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 trigger is 1 after reset
      do_push(8'h5A);
      chk_state("R1 trigger1", 1, 1, 1);
      do_pop(got);
      check("R2 pop", int'(got), 8'h5A);

      // table walk
      for (int k = 0; k < NV; k++) begin
         case (VECS[k].op)
            OP_CFG:  do_cfg(VECS[k].arg);
            OP_PUSH: do_push(VECS[k].arg);
            default: begin
               do_pop(got);
               check("R2 R10 table rd", int'(got), int'(VECS[k].rd));
            end
         endcase
         chk_state("R3 R7 R9 table", int'(VECS[k].cnt), int'(VECS[k].full), int'(VECS[k].irq));
      end

      // R8 timeout timing
      do_cfg(8'h42);
      do_push(8'h01);
      repeat (TOUT - 1) @(negedge clk);
      chk_state("R8 before expiry", 1, 0, 0);
      @(negedge clk);
      chk_state("R8 at expiry", 1, 1, 1);

      // R8 restart by second byte
      do_cfg(8'h42);
      do_push(8'h02);
      repeat (30) @(negedge clk);
      do_push(8'h03);
      repeat (TOUT - 1) @(negedge clk);
      chk_state("R8 restarted", 2, 0, 0);
      @(negedge clk);
      chk_state("R8 restarted expiry", 2, 1, 1);

      // R4 flush stops the timer
      do_cfg(8'h42);
      do_push(8'h04);
      repeat (10) @(negedge clk);
      do_cfg(8'h42);
      repeat (TOUT + 5) @(negedge clk);
      chk_state("R4 timer stopped", 0, 0, 0);

      // R6 overflow and R2 order across wrap
      do_cfg(8'hC2);
      for (int k = 0; k < 16; k++) begin
         do_push(8'h30 + 8'(k));
         if (k == 12) chk_state("R7 below 14", 13, 0, 0);
         if (k == 13) chk_state("R7 reach 14", 14, 1, 1);
      end
      do_push(8'hEE);
      chk_state("R6 discard", 16, 1, 1);
      // R6 push with pop at 16: push dropped
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'hEF; rd_pop = 1'b1; got = rd_data;
      @(negedge clk); rx_valid = 1'b0; rd_pop = 1'b0;
      check("R6 R2 head", int'(got), 8'h30);
      check("R6 count", int'(fill_count), 15);
      for (int k = 1; k < 16; k++) begin
         do_pop(got);
         check("R2 order", int'(got), 8'h30 + k);
         if (k == 2) chk_state("R9 at 13", 13, 0, 0);
      end
      check("R6 EE/EF dropped", int'(fill_count), 0);

      // R11 simultaneous push and pop
      do_cfg(8'hC2);
      do_push(8'h61); do_push(8'h62); do_push(8'h63);
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'h64; rd_pop = 1'b1; got = rd_data;
      @(negedge clk); rx_valid = 1'b0; rd_pop = 1'b0;
      check("R11 head", int'(got), 8'h61);
      check("R11 count", int'(fill_count), 3);
      do_pop(got);
      check("R11 next", int'(got), 8'h62);

      // R5 receive disabled
      do_cfg(8'h02);
      rx_en = 1'b0;
      do_push(8'h70);
      chk_state("R5 ignored", 0, 0, 0);
      check("R10 rd_data empty", int'(rd_data), 0);
      rx_en = 1'b1;

      // R7 interrupt disabled: full only
      rxi_en = 1'b0;
      do_push(8'h71);
      chk_state("R7 no irq", 1, 1, 0);
      rxi_en = 1'b1;
      do_pop(got);
      chk_state("R9 cleared", 0, 0, 0);

      // R12 interrupt drops with enable
      do_push(8'h72);
      chk_state("R12 raised", 1, 1, 1);
      @(negedge clk); rxi_en = 1'b0;
      @(negedge clk);
      chk_state("R12 dropped", 1, 1, 0);
      rxi_en = 1'b1;

      finish_run();
   end

endmodule